// File: doc/BRIEF.md
# Spinlock Traffic Generator

This block is a synthetic bus master that puts lock contention on a coherent memory system. It acquires and releases a byte-wide spinlock over and over, using test-and-test-and-set. First it reads the lock word until the word looks free. Then it tries an atomic swap that stores the locked byte. If the swap returns the free byte, the block owns the lock. It holds the lock for a programmed time and then writes the free byte back. Three programmable delays set the pacing: a think time between iterations, a wait time between retries, and a hold time while the lock is owned. After a programmed number of completed releases the block stops and raises `done`.

The block sends requests on a valid/ready channel with an opcode, a byte address and a write byte. It accepts responses on a valid-only channel that returns the address and the old data byte. Only one request is outstanding at any time. For every successful test, every swap and every release, the block reports the number of cycles from request acceptance to response. The lock address is one of `NUM_LOCKS` cache lines starting at `LOCK_BASE`. A 16-bit LFSR picks the line.

Top module: `spinlock_tgen`

## Requirements
- R1: While reset is held, `done` and `err` are 0. The block comes out of reset ready to test and presents a read request in the first cycle after reset is released. The read goes to `LOCK_BASE + (LFSR_SEED mod NUM_LOCKS) * LINE_BYTES`.
- R2: Each request has a fixed encoding. A test read uses opcode 1 with write byte 0x00. A swap uses opcode 2 with write byte `LOCKED_VAL`. A release write uses opcode 3 with write byte `UNLOCKED_VAL`. Every request goes to the current lock address. While `req_valid` is high and `req_ready` is low, opcode, address and data stay unchanged.
- R3: A delay D is loaded in the response cycle. The next request is then presented exactly D cycles after that response edge, so a delay of 0 presents the request in the next cycle.
- R4: A test read that returns `LOCKED_VAL` leads to another test read after the wait delay. Any other returned byte leads to a swap after the wait delay.
- R5: A swap that returns `LOCKED_VAL` has failed and leads to a test read after the wait delay. Any other returned byte means the lock is owned, and a release write follows after the hold delay.
- R6: Each release response counts one iteration. If the count is below `cfg_iters`, a test read follows after the think delay. If the count has reached `cfg_iters`, `done` rises, stays high, and no further request is presented. A limit of 0 behaves like a limit of 1.
- R7: Once a request is accepted, `req_valid` stays low until its response has been consumed.
- R8: Latency strobes appear in the cycle after the response, with `lat_cycles` equal to the number of clock edges from the accepting edge to the response edge. `test_lat_vld` pulses only for a test that returned a byte other than `LOCKED_VAL`. `swap_lat_vld` pulses for every swap and `rel_lat_vld` for every release. At most one strobe is high in any cycle.
- R9: `err` is sticky and is set in either of two cases: a response arrives while no request is outstanding, or a response's address differs from the lock address. A mismatched response is still consumed, so the sequence goes on.
- R10: The lock address changes only when a release completes below the limit. At that point the LFSR steps once: it shifts left and feeds back bit15^bit13^bit12^bit10 into bit 0. The new address is `LOCK_BASE + (lfsr mod NUM_LOCKS) * LINE_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_think | input | 16 | Cycles to wait between iterations |
| cfg_wait | input | 16 | Cycles to wait before a retry or a swap |
| cfg_hold | input | 16 | Cycles to hold the lock before releasing it |
| cfg_iters | input | ITER_W | Number of releases before stopping |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted this cycle |
| req_op | output | 2 | 1 read, 2 swap, 3 write |
| req_addr | output | ADDR_W | Lock byte address |
| req_wdata | output | 8 | Byte stored by a swap or write |
| rsp_valid | input | 1 | Response present |
| rsp_addr | input | ADDR_W | Address the response belongs to |
| rsp_data | input | 8 | Old lock byte |
| test_lat_vld | output | 1 | Latency of a test that found the lock free |
| swap_lat_vld | output | 1 | Latency of a swap |
| rel_lat_vld | output | 1 | Latency of a release |
| lat_cycles | output | LAT_W | Measured latency |
| done | output | 1 | All iterations finished |
| err | output | 1 | Sticky protocol error |

## Verification
The bench sweeps a grid of delay settings and response latencies, including 0, 1 and 3. This separates off-by-one errors in each delay from errors in the latency count. Half the runs stall `req_ready` for two cycles, which checks request stability and shows that a stall does not count toward latency. Other runs make a phantom owner keep the lock busy and steal it between a successful test and the swap. That forces both the spin path and the failed-swap path, so an outcome decoded from the wrong byte or the wrong state shows up. Separate runs cover a limit of 0, a mismatched response address, and a stray response after `done`.

// File: rtl/spinlock_tgen.sv
module spinlock_tgen #(
  parameter int               ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] LOCK_BASE   = 'h1000,
  parameter int               LINE_BYTES   = 64,
  parameter int               NUM_LOCKS    = 4,
  parameter logic [15:0]      LFSR_SEED    = 16'hACE1,
  parameter logic [7:0]       LOCKED_VAL   = 8'h01,
  parameter logic [7:0]       UNLOCKED_VAL = 8'h00,
  parameter int               ITER_W       = 16,
  parameter int               LAT_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cfg_think,
  input  logic [15:0]       cfg_wait,
  input  logic [15:0]       cfg_hold,
  input  logic [ITER_W-1:0] cfg_iters,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [7:0]        rsp_data,
  output logic              test_lat_vld,
  output logic              swap_lat_vld,
  output logic              rel_lat_vld,
  output logic [LAT_W-1:0]  lat_cycles,
  output logic              done,
  output logic              err
);

  typedef enum logic [2:0] {
    S_THINK, S_TEST_PEND, S_PRE_SWAP, S_SWAP_PEND, S_HOLD, S_REL_PEND, S_DONE
  } state_t;

  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_SWAP = 2'd2;
  localparam logic [1:0] OP_WR   = 2'd3;

  state_t             state;
  logic [15:0]        dly;
  logic [15:0]        lfsr;
  logic [ITER_W-1:0]  iter;
  logic [LAT_W-1:0]   lat;
  logic [ADDR_W-1:0]  lock_addr;
  logic [ITER_W-1:0]  iter_inc;
  logic               waiting, pending, rsp_locked, more_iters;

  assign waiting    = (state == S_THINK) || (state == S_PRE_SWAP) || (state == S_HOLD);
  assign pending    = (state == S_TEST_PEND) || (state == S_SWAP_PEND) || (state == S_REL_PEND);
  assign rsp_locked = (rsp_data == LOCKED_VAL);
  assign iter_inc   = iter + ITER_W'(1);
  assign more_iters = (iter_inc < cfg_iters);
  assign lock_addr  = LOCK_BASE + ADDR_W'(lfsr % 16'(NUM_LOCKS)) * ADDR_W'(LINE_BYTES);

  assign req_valid = waiting && (dly == 16'd0);
  assign req_addr  = lock_addr;
  assign done      = (state == S_DONE);

  always_comb begin
    case (state)
      S_THINK:    begin req_op = OP_RD;   req_wdata = 8'h00;        end
      S_PRE_SWAP: begin req_op = OP_SWAP; req_wdata = LOCKED_VAL;   end
      S_HOLD:     begin req_op = OP_WR;   req_wdata = UNLOCKED_VAL; end
      default:    begin req_op = 2'd0;    req_wdata = 8'h00;        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_THINK;
      dly          <= 16'd0;
      lfsr         <= LFSR_SEED;
      iter         <= '0;
      lat          <= '0;
      lat_cycles   <= '0;
      test_lat_vld <= 1'b0;
      swap_lat_vld <= 1'b0;
      rel_lat_vld  <= 1'b0;
      err          <= 1'b0;
    end else begin
      test_lat_vld <= 1'b0;
      swap_lat_vld <= 1'b0;
      rel_lat_vld  <= 1'b0;
      if (rsp_valid && (!pending || rsp_addr != lock_addr)) err <= 1'b1;

      if (waiting) begin
        if (dly != 16'd0) begin
          dly <= dly - 16'd1;
        end else if (req_ready) begin
          lat <= LAT_W'(1);
          case (state)
            S_THINK:    state <= S_TEST_PEND;
            S_PRE_SWAP: state <= S_SWAP_PEND;
            default:    state <= S_REL_PEND;
          endcase
        end
      end else if (pending) begin
        if (!rsp_valid) begin
          if (lat != '1) lat <= lat + LAT_W'(1);
        end else begin
          lat_cycles <= lat;
          case (state)
            S_TEST_PEND: begin
              dly          <= cfg_wait;
              state        <= rsp_locked ? S_THINK : S_PRE_SWAP;
              test_lat_vld <= !rsp_locked;
            end
            S_SWAP_PEND: begin
              swap_lat_vld <= 1'b1;
              dly          <= rsp_locked ? cfg_wait : cfg_hold;
              state        <= rsp_locked ? S_THINK : S_HOLD;
            end
            default: begin
              rel_lat_vld <= 1'b1;
              iter        <= iter_inc;
              if (more_iters) begin
                state <= S_THINK;
                dly   <= cfg_think;
                lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              end else begin
                state <= S_DONE;
              end
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spinlock_tgen_chk.sv
module spinlock_tgen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_wdata,
  input logic              rsp_valid,
  input logic              test_lat_vld,
  input logic              swap_lat_vld,
  input logic              rel_lat_vld,
  input logic              done,
  input logic              err,
  input logic [2:0]        st
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_wdata)); // R2

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid); // R7

  AST_ADDR_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(req_addr) |-> (st == 3'd0) && ($past(st) == 3'd5)); // R10

  AST_ONE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({test_lat_vld, swap_lat_vld, rel_lat_vld}) <= 1); // R8

  AST_LAT_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (test_lat_vld || swap_lat_vld || rel_lat_vld) |-> $past(rsp_valid)); // R8

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !req_valid); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9

  AST_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !((st == 3'd1) || (st == 3'd3) || (st == 3'd5)) |=> err); // R9

endmodule

bind spinlock_tgen spinlock_tgen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .test_lat_vld(test_lat_vld), .swap_lat_vld(swap_lat_vld), .rel_lat_vld(rel_lat_vld),
  .done(done), .err(err), .st(state)
);

// File: tb/spinlock_tgen_tb.sv
module spinlock_tgen_tb;
  localparam int          NL   = 3;
  localparam logic [31:0] BASE = 32'h1000;
  localparam int          LINE = 64;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [7:0]  LK   = 8'h01;
  localparam logic [7:0]  UL   = 8'h00;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_ready, rsp_valid;
  logic [15:0] cfg_think, cfg_wait, cfg_hold, cfg_iters;
  logic [31:0] rsp_addr;
  logic [7:0]  rsp_data;
  logic        req_valid, test_lat_vld, swap_lat_vld, rel_lat_vld, done, err;
  logic [1:0]  req_op;
  logic [31:0] req_addr;
  logic [7:0]  req_wdata;
  logic [15:0] lat_cycles;

  spinlock_tgen #(.ADDR_W(32), .LOCK_BASE(BASE), .LINE_BYTES(LINE), .NUM_LOCKS(NL),
                  .LFSR_SEED(SEED), .LOCKED_VAL(LK), .UNLOCKED_VAL(UL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_think(cfg_think), .cfg_wait(cfg_wait),
    .cfg_hold(cfg_hold), .cfg_iters(cfg_iters), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .test_lat_vld(test_lat_vld), .swap_lat_vld(swap_lat_vld), .rel_lat_vld(rel_lat_vld),
    .lat_cycles(lat_cycles), .done(done), .err(err));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_step(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  function automatic logic [31:0] addr_of(input logic [15:0] l);
    return BASE + 32'(l % NL) * LINE;
  endfunction

  task automatic run(input int think, input int wt, input int hold, input int iters,
                     input int lat, input bit stall, input bit contend, input bit mismatch);
    logic [7:0]  mem [NL];
    logic [15:0] lm = SEED;
    logic [7:0]  d;
    logic [31:0] cur_addr = '0;
    int  exp_op = 1, exp_d = 0, rsp_edge = 0, h = 0, stall_left = 0, it = 0;
    int  busy = 0, steal = 0, exp_str = 0, cur_op = 0, guard = 0, idx;
    bit  outst = 0, seen = 0, exp_done = 0, finished = 0, str_due = 0, first = 1;
    bit  exp_err = 0, mm_pending = mismatch;

    for (int i = 0; i < NL; i++) mem[i] = UL;
    if (contend) begin mem[lm % NL] = LK; busy = 2; steal = 1; end
    rst_n = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0; rsp_addr = '0; rsp_data = '0;
    cfg_think = 16'(think); cfg_wait = 16'(wt); cfg_hold = 16'(hold); cfg_iters = 16'(iters);
    repeat (3) @(negedge clk);
    chk("R1 done during reset", done, 0);
    chk("R1 err during reset", err, 0);
    rst_n = 1'b1;
    rsp_edge = cyc;

    while (!finished && guard < 4000) begin
      guard++;
      req_ready = 1'b0;
      rsp_valid = 1'b0;
      if (str_due) begin
        str_due = 0;
        chk("R8 latency strobes", {rel_lat_vld, swap_lat_vld, test_lat_vld}, exp_str);
        if (exp_str != 0) chk("R8 latency value", lat_cycles, lat);
        chk("R9 error flag", err, exp_err);
        if (exp_done) begin
          chk("R6 done raised", done, 1);
          for (int q = 0; q < 3; q++) begin
            chk("R6 no request after done", req_valid, 0);
            @(negedge clk);
          end
          rsp_valid = 1'b1; rsp_addr = cur_addr; rsp_data = UL;
          @(negedge clk);
          rsp_valid = 1'b0;
          chk("R9 stray response flags error", err, 1);
          chk("R6 done stays high", done, 1);
          finished = 1;
          continue;
        end
      end
      if (outst) begin
        chk("R7 no request while outstanding", req_valid, 0);
        if (cyc == h + lat - 1) begin
          idx = int'(lm % NL);
          d = 8'h00;
          case (cur_op)
            1: begin
              d = mem[idx];
              exp_d = wt;
              if (d == LK) begin
                exp_op = 1; exp_str = 0;
                if (busy > 0) begin busy--; if (busy == 0) mem[idx] = UL; end
              end else begin
                exp_op = 2; exp_str = 1;
                if (steal > 0) begin steal--; mem[idx] = LK; busy = 2; end
              end
            end
            2: begin
              d = mem[idx]; mem[idx] = LK; exp_str = 2;
              if (d == LK) begin exp_op = 1; exp_d = wt; end
              else begin exp_op = 3; exp_d = hold; end
            end
            default: begin
              mem[idx] = UL; exp_str = 4; it++;
              if (it < ((iters == 0) ? 1 : iters)) begin
                lm = lfsr_step(lm); exp_op = 1; exp_d = think;
              end else exp_done = 1;
            end
          endcase
          rsp_valid = 1'b1; rsp_data = d; rsp_addr = cur_addr;
          if (mm_pending) begin rsp_addr = cur_addr ^ 32'h4; mm_pending = 0; exp_err = 1; end
          outst = 0; str_due = 1; rsp_edge = cyc + 1;
        end
      end else if (req_valid) begin
        if (!seen) begin
          seen = 1;
          if (first) begin
            chk("R1 first request is a read", req_op, 1);
            chk("R1 first address", req_addr, addr_of(SEED));
            first = 0;
          end
          chk("R3 delay before request", cyc - rsp_edge, exp_d);
          chk("R4/R5 opcode follows outcome", req_op, exp_op);
          chk("R10 lock address", req_addr, addr_of(lm));
          chk("R2 write byte", req_wdata, (exp_op == 2) ? LK : ((exp_op == 3) ? UL : 8'h00));
          stall_left = stall ? 2 : 0;
        end
        if (stall_left > 0) begin
          stall_left--;
        end else begin
          req_ready = 1'b1; outst = 1; seen = 0; h = cyc + 1;
          cur_op = int'(req_op); cur_addr = req_addr;
        end
      end else if (seen) begin
        chk("R2 request held during stall", req_valid, 1);
      end
      @(negedge clk);
    end
    chk("R6 run completed", finished, 1);
    req_ready = 1'b0;
    rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0;
    rsp_addr = '0; rsp_data = '0;
    cfg_think = '0; cfg_wait = '0; cfg_hold = '0; cfg_iters = '0;
    @(negedge clk);
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 2; c++)
          for (int e = 0; e < 2; e++)
            run(a * 2, b, c * 3, 3, 1 + e * 2, bit'(a ^ e), bit'(b ^ c), 1'b0);
    run(1, 2, 1, 0, 2, 1'b0, 1'b0, 1'b0);
    run(0, 0, 0, 2, 1, 1'b0, 1'b1, 1'b1);
    run(5, 4, 6, 4, 4, 1'b1, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule